// File: doc/BRIEF.md
# Serial Bus Hang Timeout Monitor

This block watches a two-wire serial bus controller and flags a hang. The only link to the controller is its pending-interrupt flag. While the monitor is enabled and that flag is low, a window counter advances by one on every system clock. Whenever the controller raises its flag, the counter is held at zero. It starts again from zero once the flag drops. So the counter only reaches its limit when the controller has stayed silent for a full window. When it overflows, a sticky timeout flag is set and an interrupt request goes to the processor.

Software clears the timeout flag by writing a one to the clear bit. Clearing the enable bit stops the counter and returns it to zero, so every re-enable opens a fresh window. A mode machine with three states drives the counter:

- `HM_OFF`: monitor disabled, counter at zero.
- `HM_HOLD`: enabled, controller flag high, counter held at zero.
- `HM_RUN`: enabled, controller flag low, counter advancing.

The next state is chosen every cycle from the inputs:

- Any state goes to `HM_OFF` when the enable is low.
- Any state goes to `HM_HOLD` when the enable and the controller flag are both high.
- Any state goes to `HM_RUN` when the enable is high and the controller flag is low.

The counter acts on that next state in the same cycle.

Top module: `bus_hang_monitor`

## Requirements
- R1: A synchronous active-high reset clears the counter, the timeout flag and the interrupt request to 0.
- R2: While the enable is high and the controller flag is low, the 14-bit counter advances by one per clock. The timeout flag rises at the clock edge that ends the 16384th consecutive counting cycle.
- R3: The interrupt request equals the timeout flag on every cycle. It rises and falls at the same edges.
- R4: The timeout flag is sticky. It stays high through further counting, including a second overflow, until it is cleared.
- R5: A write with bit 0 of the write data at 1 clears the timeout flag at that clock edge. A write with bit 0 at 0 leaves the flag unchanged.
- R6: If a clear write and an overflow fall on the same clock edge, the flag is 1 after that edge.
- R7: While the enable and the controller flag are both high, the counter is held at zero. After the controller flag falls, a full 16384-cycle window is needed before a timeout.
- R8: While the enable is low the counter stops at zero. After re-enabling, a full 16384-cycle window is needed before a timeout.
- R9: On overflow the counter wraps to zero. The next overflow comes 16384 counting cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tmo_en | input | 1 | Timeout monitor enable |
| si_flag | input | 1 | Controller pending-interrupt flag |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; bit 0 = 1 clears the timeout flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Timeout interrupt request |

## Verification
Every result of this block is due at the first clock edge after the inputs that cause it:
- A counting step lands at that edge.
- An overflow sets the flag and the interrupt request at the edge that counts the last value.
- A clear write takes effect at the edge it is presented on.

The driver sets inputs on the falling edge and runs a reference count of the window. Before the next rising edge it queues the flag value expected after that edge. The monitor pops and compares one nanosecond after each rising edge, so each comparison lines up with exactly one edge. Windows are timed from the reference count, so the overflow edge, the coincident clear and the restarts after a hold or a disable are all hit on the exact cycle.

// File: rtl/bus_hang_pkg.sv
package bus_hang_pkg;

    // Operating mode of the hang monitor
    typedef enum logic [1:0] {
        HM_OFF  = 2'd0,
        HM_HOLD = 2'd1,
        HM_RUN  = 2'd2
    } hm_state_e;

endpackage

// File: rtl/hm_mode_fsm.sv
module hm_mode_fsm
    import bus_hang_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      si,
    output hm_state_e state_q,
    output logic      cnt_inc,
    output logic      cnt_clr
);

    hm_state_e state_d;

    // next-state selection
    always_comb begin
        if (!en) begin
            state_d = HM_OFF;
        end else if (si) begin
            state_d = HM_HOLD;
        end else begin
            state_d = HM_RUN;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HM_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // counter control from the chosen mode
    always_comb begin
        cnt_inc = 1'b0;
        cnt_clr = 1'b0;
        unique case (state_d)
            HM_OFF:  cnt_clr = 1'b1;
            HM_HOLD: cnt_clr = 1'b1;
            HM_RUN:  cnt_inc = 1'b1;
            default: cnt_clr = 1'b1;
        endcase
    end

    // R7: a hold request with the monitor enabled lands in HM_HOLD
    assert_hold_entry_R7: assert property (@(posedge clk) disable iff (rst)
        (en && si) |=> (state_q == HM_HOLD));

endmodule

// File: rtl/hm_window_counter.sv
module hm_window_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign wrap = inc && (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2: one step per counting cycle
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && !wrap) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R9: wrap returns the count to zero
    assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/hm_sticky_flag.sv
module hm_sticky_flag #(
    parameter int DATA_W  = 8,
    parameter int CLR_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              flag_q,
    output logic              irq_q
);

    logic clr_req;
    logic flag_d;
    logic unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign clr_req        = wr_en && wr_data[CLR_BIT];

    // overflow has priority over a clear
    always_comb begin
        if (set) begin
            flag_d = 1'b1;
        end else if (clr_req) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            irq_q  <= flag_d;
        end
    end

    // R4: flag holds without a clear
    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);

    // R6: overflow beats a clear on the same edge
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (set && clr_req) |=> flag_q);

    // R3: request mirrors the flag
    assert_irq_match_R3: assert property (@(posedge clk) disable iff (rst)
        irq_q == flag_q);

endmodule

// File: rtl/bus_hang_monitor.sv
module bus_hang_monitor
    import bus_hang_pkg::*;
#(
    parameter int CNT_W   = 14,
    parameter int DATA_W  = 8,
    parameter int CLR_BIT = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmo_en,
    input  logic              si_flag,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tmo_flag,
    output logic              tmo_irq
);

    hm_state_e        mode_q;
    logic             cnt_inc;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_wrap;

    hm_mode_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en      (tmo_en),
        .si      (si_flag),
        .state_q (mode_q),
        .cnt_inc (cnt_inc),
        .cnt_clr (cnt_clr)
    );

    hm_window_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (cnt_inc),
        .clr   (cnt_clr),
        .cnt_q (cnt_q),
        .wrap  (cnt_wrap)
    );

    hm_sticky_flag #(.DATA_W(DATA_W), .CLR_BIT(CLR_BIT)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .set     (cnt_wrap),
        .wr_en   (wr_stb),
        .wr_data (wr_data),
        .flag_q  (tmo_flag),
        .irq_q   (tmo_irq)
    );

    // R8: disabled monitor holds a zero count
    assert_off_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == HM_OFF) |-> (cnt_q == '0));

    // R7: hold state holds a zero count
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == HM_HOLD) |-> (cnt_q == '0));

    // R1: reset leaves flag and request low
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!tmo_flag && !tmo_irq && cnt_q == '0));

endmodule

// File: tb/bus_hang_monitor_tb_top.sv
`timescale 1ns/1ps
module bus_hang_monitor_tb_top;

    localparam int WIN = 16384;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tmo_en = 1'b0;
    logic       si_flag = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tmo_flag;
    logic       tmo_irq;

    int  total = 0;
    int  bad = 0;
    int  cycles = 0;
    bit  done = 1'b0;

    int  mcnt = 0;
    bit  mtif = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    bus_hang_monitor dut_i (
        .clk      (clk),
        .rst      (rst),
        .tmo_en   (tmo_en),
        .si_flag  (si_flag),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .tmo_flag (tmo_flag),
        .tmo_irq  (tmo_irq)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected flag
    task automatic step(input bit r, input bit en, input bit si,
                        input bit wr, input logic [7:0] d, input string tag);
        bit run;
        bit ovf;
        @(negedge clk);
        rst = r; tmo_en = en; si_flag = si; wr_stb = wr; wr_data = d;
        if (r) begin
            mcnt = 0;
            mtif = 1'b0;
        end else begin
            run = en && !si;
            ovf = run && (mcnt == WIN - 1);
            mcnt = run ? (mcnt + 1) % WIN : 0;
            if (ovf) mtif = 1'b1;
            else if (wr && d[0]) mtif = 1'b0;
        end
        exp_q.push_back(mtif);
        tag_q.push_back(tag);
    endtask

    task automatic run_n(input int n, input bit en, input bit si, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, en, si, 1'b0, 8'h00, tag);
    endtask

    // count until the reference count reaches the given value
    task automatic run_to(input int v, input string tag);
        while (mcnt != v) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, tag);
    endtask

    // monitor: compare one nanosecond after every rising edge
    always begin
        @(posedge clk);
        #1;
        cycles++;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (tmo_flag !== e) begin
                bad++;
                $display("FAIL %s flag actual=%b expected=%b", t, tmo_flag, e);
            end
            total++;
            if (tmo_irq !== e) begin
                bad++;
                $display("FAIL R3 (%s) irq actual=%b expected=%b", t, tmo_irq, e);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 190000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R1");
        // R2: a full quiet window sets the flag at the exact edge
        run_n(WIN - 1, 1'b1, 1'b0, "R2");
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R2");
        // R4: flag stays through more counting
        run_n(40, 1'b1, 1'b0, "R4");
        // R5: a write of zero leaves the flag, a write of one clears it
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'hFE, "R5");
        run_n(3, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, "R5");
        run_n(3, 1'b1, 1'b0, "R5");
        // R9: the count wrapped, the next overflow is one window after the first
        run_to(WIN - 1, "R9");
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R9");
        // R4: a second overflow while set keeps it set
        run_to(WIN - 1, "R4");
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R4");
        // R6: a clear on the overflow edge loses
        run_to(WIN - 1, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, "R6");
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, "R5");
        // R7: controller flag holds the count at zero; a full window follows
        run_to(9000, "R7");
        run_n(30, 1'b1, 1'b1, "R7");
        run_n(WIN - 1, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b1, 8'h01, "R5");
        // R8: disabling stops and zeroes; re-enable opens a full window
        run_to(12000, "R8");
        run_n(25, 1'b0, 1'b0, "R8");
        run_n(WIN - 1, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R8");
        // R1: reset clears a set flag
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R1");
        run_n(5, 1'b1, 1'b0, "R1");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule